// File: doc/BRIEF.md
# Edge-Triggered Masked Interrupt Aggregator

This block watches four asynchronous condition lines: left jack presence, right jack presence, microphone short-circuit and microphone presence. It turns every change on them into a latched interrupt event, and it drives a single combined interrupt line toward the next interrupt tier. Each line is resynchronized into the local clock domain. Both a rising and a falling level change set that line's sticky status bit.

Software reads the status word through a small register port, and that read clears the status. A mask register with one bit per source decides which status bits may raise the combined line. Masking acts only on the combined output: a masked source still records its events, so software can poll them.

Top module: `irq_edge_aggregator`

## Requirements
- R1: After reset the status field and the mask field read as zero and `irq_o` is low.
- R2: A rising change on `src_i[k]` sets status bit 8+k. The mapping is src_i[3] left jack to bit 11, src_i[2] right jack to bit 10, src_i[1] mic short to bit 9 and src_i[0] mic detect to bit 8.
- R3: A falling change on `src_i[k]` also sets status bit 8+k.
- R4: A status bit stays set after its source returns to its earlier level, and several changes between reads leave a single set bit. It clears only through a status read.
- R5: A read at address 0 returns the status in bits 11:8 and clears it at that clock edge, so an immediate second read returns zero.
- R6: A change that is detected in the same cycle as a clearing status read leaves its own bit set after the read. The bits that the read returned are cleared.
- R7: A write at address 1 loads mask bits 11:8 from the write data, and a read at address 1 returns them. A mask bit of 1 blocks that source from `irq_o`.
- R8: `irq_o` is high exactly when some status bit is set with its mask bit 0. A masked source still sets its status bit.
- R9: All other bit positions read as zero. A read of any address other than 0 or 1 returns zero, and a mask read does not clear the status.
- R10: Each input passes two synchronizer flops. A level change applied between clock edges appears in the status and on `irq_o` after the third rising edge, not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 4 | Asynchronous condition lines (3 left jack, 2 right jack, 1 mic short, 0 mic detect) |
| rd_en_i | input | 1 | Read strobe; a status read clears the status |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register address (0 status, 1 mask) |
| wdata_i | input | 16 | Write data; mask taken from bits 11:8 |
| rdata_o | output | 16 | Read data, zero when no read is active |
| irq_o | output | 1 | Combined first-level interrupt |

## Verification
The sources are driven with single rising changes, single falling changes, short up-and-down pulses, and several lines changing together. These patterns separate edge detection on both polarities from plain level or single-edge capture, and they show that repeated events merge into one sticky bit. One change is timed to reach the edge detector in the same cycle as a clearing read, which separates a read that keeps the new event from one that loses it. Masked sources are toggled while `irq_o` and the status are both watched, which shows that the mask gates only the combined line. The cycle at which `irq_o` first rises is checked to confirm the synchronizer depth.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned STAT_OFFSET = 0;
  localparam int unsigned MASK_OFFSET = 1;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic         clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] chg;

  assign chg = lvl_i ^ prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_o <= '0;
    end else begin
      prev_q   <= lvl_i;
      // new events win over a same-cycle clear
      status_o <= (clr_i ? '0 : status_o) | chg;
    end
  end

  // R2 R3
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg != '0) |=> ((status_o & $past(chg)) == $past(chg)));
  // R4
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((status_o & $past(status_o)) == $past(status_o)));
  // R5
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && chg == '0) |=> (status_o == '0));
  // R6
  race_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && chg != '0) |=> (status_o == $past(chg)));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wmask_i,
  input  logic [W-1:0] status_i,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_o <= '0;
    else if (wr_en_i) mask_o <= wmask_i;
  end

  assign irq_o = |(status_i & ~mask_o);

  // R7
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (mask_o == $past(wmask_i)));
  // R8
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_i != '0));
endmodule

// File: rtl/irq_edge_aggregator.sv
module irq_edge_aggregator #(
  parameter int unsigned NUM_SRC     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned FIELD_LSB   = 8,
  parameter int unsigned ADDR_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  import irq_agg_pkg::*;

  localparam int unsigned FIELD_MSB = FIELD_LSB + NUM_SRC - 1;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFFSET);
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(MASK_OFFSET);

  logic [NUM_SRC-1:0] src_sync;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] mask;
  logic               stat_rd;
  logic               mask_wr;

  assign stat_rd = rd_en_i && (addr_i == STAT_ADDR);
  assign mask_wr = wr_en_i && (addr_i == MASK_ADDR);

  irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (src_sync)
  );

  irq_edge_latch #(.W(NUM_SRC)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (src_sync),
    .clr_i   (stat_rd),
    .status_o(status)
  );

  irq_combine #(.W(NUM_SRC)) u_comb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (mask_wr),
    .wmask_i (wdata_i[FIELD_MSB:FIELD_LSB]),
    .status_i(status),
    .mask_o  (mask),
    .irq_o   (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (addr_i == STAT_ADDR)      rdata_o[FIELD_MSB:FIELD_LSB] = status;
      else if (addr_i == MASK_ADDR) rdata_o[FIELD_MSB:FIELD_LSB] = mask;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  // R9
  mask_rd_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == MASK_ADDR) |=> ((status & $past(status)) == $past(status)));
endmodule

// File: tb/sim_irq_edge_aggregator.sv
module sim_irq_edge_aggregator;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  src = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  irq_edge_aggregator u0 (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .rd_en_i(rd_en),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    #1;
    if (rd_en) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: actual %h expected none", rdata);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rdata, e);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_read(input logic [1:0] a, input logic [15:0] e, input string t);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    tick(1);
    rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick(1);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    tick(2);
    // R1
    check("R1 irq", {15'b0, irq}, 16'h0);
    do_read(2'd0, 16'h0000, "R1 status");
    do_read(2'd1, 16'h0000, "R1 mask");

    // R10 / R2: rising mic detect
    src = 4'b0001;
    tick(2);
    check("R10 irq not yet", {15'b0, irq}, 16'h0);
    tick(1);
    check("R10 irq at third edge", {15'b0, irq}, 16'h1);
    do_read(2'd0, 16'h0100, "R2 rise");
    do_read(2'd0, 16'h0000, "R5 cleared");
    check("R8 irq low after clear", {15'b0, irq}, 16'h0);

    // R3: falling
    src = 4'b0000;
    tick(3);
    do_read(2'd0, 16'h0100, "R3 fall");

    // R4: short pulse on right jack, two edges, one bit
    src = 4'b0100;
    tick(2);
    src = 4'b0000;
    tick(5);
    check("R4 irq held", {15'b0, irq}, 16'h1);
    do_read(2'd0, 16'h0400, "R4 sticky");

    // several lines together
    src = 4'b1010;
    tick(3);
    do_read(2'd0, 16'h0A00, "R2 multi");

    // R7: mask left jack, junk in other bits
    do_write(2'd1, 16'hF8FF);
    do_read(2'd1, 16'h0800, "R7 mask readback");
    src = 4'b0010;
    tick(3);
    check("R7 masked irq low", {15'b0, irq}, 16'h0);
    do_read(2'd1, 16'h0800, "R9 mask read");
    do_read(2'd0, 16'h0800, "R8 masked sets status");
    src = 4'b0110;
    tick(3);
    check("R8 unmasked irq", {15'b0, irq}, 16'h1);
    do_read(2'd3, 16'h0000, "R9 other addr");
    do_read(2'd0, 16'h0400, "R9 status kept");

    // R6: change reaches detector in clearing-read cycle
    src = 4'b0111;
    tick(3);
    src = 4'b0101;
    tick(2);
    do_read(2'd0, 16'h0100, "R6 old bits");
    do_read(2'd0, 16'h0200, "R6 new bit kept");

    // R8: unmasking exposes a pending masked event
    src = 4'b1101;
    tick(3);
    check("R8 masked pending", {15'b0, irq}, 16'h0);
    do_write(2'd1, 16'h0000);
    check("R8 unmask raises irq", {15'b0, irq}, 16'h1);
    do_read(2'd0, 16'h0800, "R8 pending status");
    check("R8 irq after clear", {15'b0, irq}, 16'h0);

    tick(2);
    check("scoreboard drained", 16'(exp_q.size()), 16'h0);
    finish_sim();
  end
endmodule